// File: doc/BRIEF.md
# Read-After-Write Register Conflict Detector

This block decides, within a single cycle, whether a younger instruction waiting in the operand-fetch stage reads a register that an older in-flight instruction is going to write. Each side is a decoded instruction packet. The younger one is the consumer and the older one is the producer. The block returns one conflict bit. It works out the registers that are really read or written from the opcode and does not take them straight from the register fields. A store reads its rd field as a second source. A return reads the link register r15 and a call writes it. Register moves and bitwise inversion have no first source. Immediate forms drop the second source.

The block has no clock and holds no state. A stall controller would place one copy against each older stage (execute, memory access, write-back) and OR the three results. Stall policy and forwarding are outside this block. Every pin is a plain level signal and there is no handshake, because nothing here is queued or held.

Top module: `raw_conflict_chk`

## Requirements
- R1: Register fields are 4 bits wide and the opcode is 5 bits, with these codes: nop=0, add=1, sub=2, mul=3, div=4, mod=5, cmp=6, and=7, or=8, not=9, mov=10, lsl=11, lsr=12, asr=13, ld=14, st=15, beq=16, bgt=17, b=18, call=19, ret=20. A load (ld) reads rs1 and is detected like an ALU instruction.
- R2: A consumer whose opcode is nop, b, beq, bgt or call reads no register, so `conflict` is 0.
- R3: A producer whose opcode is nop, cmp, st, b, beq, bgt or ret writes no register, so `conflict` is 0.
- R4: By default the consumer's sources are rs1 and rs2 and the producer's destination is rd. `conflict` is 1 exactly when a valid source equals a valid destination.
- R5: For a consumer store (st) the second source is rd whatever the immediate flag is, and rs2 is ignored.
- R6: For a consumer ret the first source is r15, and rs1 is ignored.
- R7: For a consumer not or mov, rs1 is ignored because there is no first source.
- R8: For a consumer other than st with the immediate flag at 1, rs2 is ignored.
- R9: A producer call writes r15, and its rd field is ignored.
- R10: If either packet's bubble flag is 1, `conflict` is 0.
- R11: The block is purely combinational, so `conflict` follows any change of input within the same cycle.
- R12: Opcodes 21 to 31 are reserved. They neither read nor write a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_opcode | input | 5 | Consumer opcode |
| a_rd | input | 4 | Consumer rd field |
| a_rs1 | input | 4 | Consumer rs1 field |
| a_rs2 | input | 4 | Consumer rs2 field |
| a_imm | input | 1 | Consumer immediate flag |
| a_bubble | input | 1 | Consumer is a bubble |
| b_opcode | input | 5 | Producer opcode |
| b_rd | input | 4 | Producer rd field |
| b_bubble | input | 1 | Producer is a bubble |
| conflict | output | 1 | Consumer reads a register the producer writes |

## Verification
Two kinds of rule can act on the same evaluation: the opcode rules that move a source or destination onto r15, and the rules that suppress an operand. A ret consumer facing a call producer tests both link rules together. A store with the immediate flag set tests the exception to the immediate rule while the redirected rd is being compared. The bench builds these overlaps in directed cases and then in a long random stream. Every response is compared with a behavioural model that derives the reads and writes independently.

// File: rtl/raw_pkg.sv
package raw_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_MUL = 5'd3,
    OP_DIV  = 5'd4,  OP_MOD = 5'd5,  OP_CMP = 5'd6,  OP_AND = 5'd7,
    OP_OR   = 5'd8,  OP_NOT = 5'd9,  OP_MOV = 5'd10, OP_LSL = 5'd11,
    OP_LSR  = 5'd12, OP_ASR = 5'd13, OP_LD  = 5'd14, OP_ST  = 5'd15,
    OP_BEQ  = 5'd16, OP_BGT = 5'd17, OP_B   = 5'd18, OP_CALL = 5'd19,
    OP_RET  = 5'd20
  } opcode_e;
endpackage

// File: rtl/raw_src_dec.sv
module raw_src_dec #(
  parameter int REG_W = 4
) (
  input  logic [raw_pkg::OPC_W-1:0] opcode,
  input  logic [REG_W-1:0]          rd,
  input  logic [REG_W-1:0]          rs1,
  input  logic [REG_W-1:0]          rs2,
  input  logic                      imm,
  input  logic                      bubble,
  output logic [1:0]                src_vld,
  output logic [1:0][REG_W-1:0]     src
);
  import raw_pkg::*;
  localparam logic [REG_W-1:0] LINK = '1;

  opcode_e op;
  assign op = opcode_e'(opcode);

  always_comb begin
    src_vld = 2'b00;
    src[0]  = rs1;
    src[1]  = rs2;
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_CMP, OP_AND, OP_OR,
      OP_LSL, OP_LSR, OP_ASR, OP_LD: begin
        src_vld = {!imm, 1'b1};
      end
      OP_NOT, OP_MOV: begin
        src_vld = {!imm, 1'b0};
      end
      OP_ST: begin
        src_vld = 2'b11;
        src[1]  = rd;
      end
      OP_RET: begin
        src_vld = {!imm, 1'b1};
        src[0]  = LINK;
      end
      default: src_vld = 2'b00;
    endcase
    if (bubble) src_vld = 2'b00;
  end

  always_comb begin
    if (!$isunknown({opcode, imm, bubble, src_vld})) begin
      // R2
      noread_quiet_chk: assert (!(op inside {OP_NOP, OP_B, OP_BEQ, OP_BGT, OP_CALL})
                                || src_vld == 2'b00);
      // R6
      ret_link_chk: assert (!(op == OP_RET && !bubble) || (src_vld[0] && src[0] == LINK));
    end
  end
endmodule

// File: rtl/raw_dst_dec.sv
module raw_dst_dec #(
  parameter int REG_W = 4
) (
  input  logic [raw_pkg::OPC_W-1:0] opcode,
  input  logic [REG_W-1:0]          rd,
  input  logic                      bubble,
  output logic                      dst_vld,
  output logic [REG_W-1:0]          dst
);
  import raw_pkg::*;
  localparam logic [REG_W-1:0] LINK = '1;

  opcode_e op;
  assign op = opcode_e'(opcode);

  always_comb begin
    dst_vld = 1'b0;
    dst     = rd;
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND, OP_OR, OP_NOT,
      OP_MOV, OP_LSL, OP_LSR, OP_ASR, OP_LD: dst_vld = 1'b1;
      OP_CALL: begin
        dst_vld = 1'b1;
        dst     = LINK;
      end
      default: dst_vld = 1'b0;
    endcase
    if (bubble) dst_vld = 1'b0;
  end

  always_comb begin
    if (!$isunknown({opcode, bubble, dst_vld})) begin
      // R3
      nowrite_quiet_chk: assert (!(op inside {OP_NOP, OP_CMP, OP_ST, OP_B, OP_BEQ,
                                              OP_BGT, OP_RET}) || !dst_vld);
      // R9
      call_link_chk: assert (!(op == OP_CALL && !bubble) || (dst_vld && dst == LINK));
    end
  end
endmodule

// File: rtl/raw_conflict_chk.sv
module raw_conflict_chk #(
  parameter int REG_W = 4
) (
  input  logic [raw_pkg::OPC_W-1:0] a_opcode,
  input  logic [REG_W-1:0]          a_rd,
  input  logic [REG_W-1:0]          a_rs1,
  input  logic [REG_W-1:0]          a_rs2,
  input  logic                      a_imm,
  input  logic                      a_bubble,
  input  logic [raw_pkg::OPC_W-1:0] b_opcode,
  input  logic [REG_W-1:0]          b_rd,
  input  logic                      b_bubble,
  output logic                      conflict
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]            src_vld;
  logic [NSRC-1:0][REG_W-1:0] src;
  logic                       dst_vld;
  logic [REG_W-1:0]           dst;
  logic [NSRC-1:0]            hit;

  raw_src_dec #(.REG_W(REG_W)) u_src (
    .opcode(a_opcode), .rd(a_rd), .rs1(a_rs1), .rs2(a_rs2),
    .imm(a_imm), .bubble(a_bubble), .src_vld(src_vld), .src(src)
  );

  raw_dst_dec #(.REG_W(REG_W)) u_dst (
    .opcode(b_opcode), .rd(b_rd), .bubble(b_bubble),
    .dst_vld(dst_vld), .dst(dst)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = src_vld[i] && dst_vld && (src[i] == dst);
  end

  assign conflict = |hit;

  always_comb begin
    if (!$isunknown({a_bubble, b_bubble, conflict, src_vld, dst_vld})) begin
      // R10
      bubble_idle_chk: assert (!(a_bubble || b_bubble) || !conflict);
      // R4
      conflict_needs_ops_chk: assert (!conflict || (dst_vld && (|src_vld)));
    end
  end
endmodule

// File: tb/sim_raw_conflict_chk.sv
module sim_raw_conflict_chk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] a_opcode, b_opcode;
  logic [3:0] a_rd, a_rs1, a_rs2, b_rd;
  logic       a_imm, a_bubble, b_bubble;
  logic       conflict;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  raw_conflict_chk u0 (
    .a_opcode(a_opcode), .a_rd(a_rd), .a_rs1(a_rs1), .a_rs2(a_rs2),
    .a_imm(a_imm), .a_bubble(a_bubble), .b_opcode(b_opcode), .b_rd(b_rd),
    .b_bubble(b_bubble), .conflict(conflict)
  );

  // Behavioural model: list the registers read and the register written.
  function automatic int model(int aop, int ard, int ars1, int ars2, int aimm, int abub,
                               int bop, int brd, int bbub);
    int reads[$];
    int wr;
    if (abub != 0 || bbub != 0) return 0;
    wr = -1;
    if (bop == 19) wr = 15;
    else if ((bop >= 1 && bop <= 14 && bop != 6)) wr = brd;
    if (wr < 0) return 0;
    if (aop == 15) begin
      reads.push_back(ars1);
      reads.push_back(ard);
    end else if (aop == 20) begin
      reads.push_back(15);
      if (aimm == 0) reads.push_back(ars2);
    end else if (aop == 9 || aop == 10) begin
      if (aimm == 0) reads.push_back(ars2);
    end else if (aop >= 1 && aop <= 14) begin
      reads.push_back(ars1);
      if (aimm == 0) reads.push_back(ars2);
    end
    foreach (reads[k]) if (reads[k] == wr) return 1;
    return 0;
  endfunction

  task automatic apply(int aop, int ard, int ars1, int ars2, int aimm, int abub,
                       int bop, int brd, int bbub);
    @(negedge clk);
    a_opcode = 5'(aop); a_rd = 4'(ard); a_rs1 = 4'(ars1); a_rs2 = 4'(ars2);
    a_imm = 1'(aimm); a_bubble = 1'(abub);
    b_opcode = 5'(bop); b_rd = 4'(brd); b_bubble = 1'(bbub);
    #1;
  endtask

  task automatic chk(string tag, int exp);
    checks++;
    if (int'(conflict) != exp) begin
      failures++;
      $display("FAIL %s: conflict=%0d expected=%0d", tag, conflict, exp);
    end
  endtask

  task automatic dir(string tag, int aop, int ard, int ars1, int ars2, int aimm, int abub,
                     int bop, int brd, int bbub, int exp);
    apply(aop, ard, ars1, ars2, aimm, abub, bop, brd, bbub);
    chk(tag, exp);
    chk({tag, " model"}, model(aop, ard, ars1, ars2, aimm, abub, bop, brd, bbub));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    chk("R2 reset nop", 0);
    rst_n = 1'b1;

    // R4 default sources against rd
    dir("R4 rs1 hit",  1, 3, 1, 2, 0, 0, 2, 1, 0, 1);
    dir("R4 rs2 hit",  1, 3, 1, 2, 0, 0, 2, 2, 0, 1);
    dir("R4 miss",     1, 3, 1, 2, 0, 0, 2, 5, 0, 0);
    dir("R4 rd no read", 1, 5, 1, 2, 0, 0, 2, 5, 0, 0);
    // R1 load consumer, mov producer
    dir("R1 ld rs1",  14, 0, 8, 0, 1, 0, 10, 8, 0, 1);
    // R2 non-reading consumers
    dir("R2 beq",     16, 1, 1, 1, 0, 0, 1, 1, 0, 0);
    dir("R2 call",    19, 1, 1, 1, 0, 0, 1, 1, 0, 0);
    dir("R2 b",       18, 1, 1, 1, 0, 0, 1, 1, 0, 0);
    // R3 non-writing producers
    dir("R3 st",       1, 0, 1, 1, 0, 0, 15, 1, 0, 0);
    dir("R3 cmp",      1, 0, 1, 1, 0, 0, 6, 1, 0, 0);
    dir("R3 ret",      1, 0, 15, 15, 0, 0, 20, 15, 0, 0);
    // R5 store second source is rd
    dir("R5 st rd",   15, 7, 2, 9, 1, 0, 1, 7, 0, 1);
    dir("R5 st rs2",  15, 7, 2, 9, 0, 0, 1, 9, 0, 0);
    // R6 ret reads r15
    dir("R6 ret r15", 20, 0, 3, 0, 1, 0, 1, 15, 0, 1);
    dir("R6 ret rs1", 20, 0, 3, 0, 1, 0, 1, 3, 0, 0);
    dir("R6 ret vs call", 20, 0, 3, 0, 1, 0, 19, 4, 0, 1);
    // R7 not/mov have no first source
    dir("R7 mov rs1", 10, 0, 4, 6, 0, 0, 1, 4, 0, 0);
    dir("R7 mov rs2", 10, 0, 4, 6, 0, 0, 1, 6, 0, 1);
    dir("R7 not rs1",  9, 0, 4, 6, 1, 0, 1, 4, 0, 0);
    // R8 immediate drops second source
    dir("R8 imm rs2",  1, 0, 5, 6, 1, 0, 1, 6, 0, 0);
    dir("R8 imm rs1",  1, 0, 5, 6, 1, 0, 1, 5, 0, 1);
    // R9 call writes r15
    dir("R9 call r15", 1, 0, 15, 3, 0, 0, 19, 2, 0, 1);
    dir("R9 call rd",  1, 0, 2, 3, 0, 0, 19, 2, 0, 0);
    // R10 bubbles
    dir("R10 a bubble", 1, 0, 1, 1, 0, 1, 1, 1, 0, 0);
    dir("R10 b bubble", 1, 0, 1, 1, 0, 0, 1, 1, 1, 0);
    // R12 reserved codes
    dir("R12 a rsv",  25, 1, 1, 1, 0, 0, 1, 1, 0, 0);
    dir("R12 b rsv",   1, 1, 1, 1, 0, 0, 30, 1, 0, 0);
    // R11 same-cycle response to a change
    apply(1, 0, 7, 7, 0, 0, 1, 7, 0);
    chk("R11 rise", 1);
    b_rd = 4'd8; #1;
    chk("R11 fall", 0);

    // R11 random stream compared every clock
    for (int n = 0; n < 4000; n++) begin
      int aop, bop, ard, ars1, ars2, aimm, abub, brd, bbub;
      aop = $urandom_range(0, 31); if (n % 2 == 0) aop = $urandom_range(0, 20);
      bop = $urandom_range(0, 31); if (n % 2 == 0) bop = $urandom_range(0, 20);
      ard = $urandom_range(12, 15); ars1 = $urandom_range(12, 15);
      ars2 = $urandom_range(12, 15); brd = $urandom_range(12, 15);
      aimm = $urandom_range(0, 1);
      abub = ($urandom_range(0, 7) == 0) ? 1 : 0;
      bbub = ($urandom_range(0, 7) == 0) ? 1 : 0;
      apply(aop, ard, ars1, ars2, aimm, abub, bop, brd, bbub);
      chk("R11 random", model(aop, ard, ars1, ars2, aimm, abub, bop, brd, bbub));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule